// File: doc/BRIEF.md
# Configurable General-Purpose Pin Port

This block is a 16-pin general-purpose I/O port controlled through a small word-addressed register interface. Each pin has a 4-bit configuration field. The field picks one of several roles for the pin:

- input, which can be analog, floating, or pulled up or down;
- software-driven output, either push-pull or open-drain;
- output driven by a peripheral signal instead of software.

The configuration fields are packed eight to a 32-bit word. The port produces per-pin driver controls for a pad: a driver enable, the driven level, pull-up and pull-down enables, and an input-sampler enable.

Software can change the output latch in three ways. It can write the latch directly. It can write a combined set/clear register that changes only the selected bits in one access. It can write a clear-only register. The pin levels are captured into an input register on every clock. Pins in analog mode have their sampler switched off, so they always read 0.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous active-low reset, both configuration words read 0x44444444, so every field is 4'b0100 (floating input). The output latch reads 0. No pin drives, no pull is enabled, and every input sampler is enabled.
- R2: The input register captures `pin_in` on every rising clock edge. A read of address 2 returns the value captured at the most recent edge.
- R3: A write to address 4 sets the output latch bits given by data bits 15:0 and clears those given by data bits 31:16. Bits written as 0 keep their value. When both the set bit and the clear bit are 1 for a pin, set wins. Address 4 reads 0.
- R4: A write to address 5 clears the output latch bits given by data bits 15:0. Data bits 31:16 and zero bits have no effect. Address 5 reads 0.
- R5: In an output mode (mode bits [1:0] of the field not 00) with config bits [3:2] = 00, the pin drives push-pull: `pin_oe`=1 and `pin_dout` equals the output latch bit.
- R6: With config bits = 01 in an output mode, the pin is open-drain. A 0 is driven low (`pin_oe`=1, `pin_dout`=0) and a 1 releases the pin (`pin_oe`=0). The high level is never driven.
- R7: With config bits = 1x in an output mode, the driven value is taken from `af_in` and not from the output latch. Config bit 2 selects open-drain (1) or push-pull (0).
- R8: In input mode (mode bits = 00), `pin_oe`=0. Config bits 01 or 11 give a floating input with no pull. Config bits 10 enable a pull whose direction is the output latch bit: 1 gives pull-up and 0 gives pull-down.
- R9: Pull-up and pull-down are never enabled in any output mode or in analog mode, and never both at once.
- R10: Mode 00 with config 00 is analog: `pin_ie`=0, and the pin's input register bit reads 0 whatever the pin level.
- R11: The register map is as follows. Address 0 holds the fields for pins 0-7 and address 1 those for pins 8-15, with the field for pin k at bits [4k+3:4k] mod 32. Address 2 is read-only, and writes to it are ignored. Address 3 is the output latch, and its bits 31:16 read 0. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Word address of the register access |
| bus_wen | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Pad input levels |
| af_in | input | 16 | Peripheral output values for peripheral-driven pins |
| pin_oe | output | 16 | Pad driver enable per pin |
| pin_dout | output | 16 | Level driven when `pin_oe` is 1 |
| pin_pu | output | 16 | Weak pull-up enable |
| pin_pd | output | 16 | Weak pull-down enable |
| pin_ie | output | 16 | Input sampler enable (0 in analog mode) |

## Verification
The following properties are checked on every cycle:

- an open-drain pin never drives high;
- pulls appear only in input mode and are exclusive;
- a push-pull pin driven by the peripheral follows `af_in`;
- analog pins always hold 0 in the input register;
- set-wins and clear results after set/clear writes;
- the configuration words stay stable when they are not written.

Other behaviour can only be shown by the bench's scenarios. The bench sweeps all sixteen field values over all pins with two data patterns. It also runs one mixed configuration in which each pin has a different field, and a sequence of pseudo-random set/clear writes. It covers read-back values, the one-edge capture delay of the input register, and ignored writes.

// File: rtl/gpio_cfg_pkg.sv
// Package: shared constants and types for the pin port.
// Assumes a word-addressed register interface of eight locations.
package gpio_cfg_pkg;
    localparam int unsigned REG_AW  = 3;
    localparam int unsigned FIELD_W = 4;

    localparam logic [REG_AW-1:0] A_CFG_LO = 3'd0;
    localparam logic [REG_AW-1:0] A_CFG_HI = 3'd1;
    localparam logic [REG_AW-1:0] A_IDR    = 3'd2;
    localparam logic [REG_AW-1:0] A_ODR    = 3'd3;
    localparam logic [REG_AW-1:0] A_BSR    = 3'd4;
    localparam logic [REG_AW-1:0] A_CLR    = 3'd5;

    // Reset field value: floating input (config 01, mode 00).
    localparam logic [FIELD_W-1:0] FIELD_RST = 4'b0100;

    // Meaning of the config bits while the mode bits are 00.
    typedef enum logic [1:0] {
        IN_ANALOG = 2'b00,
        IN_FLOAT  = 2'b01,
        IN_PULL   = 2'b10,
        IN_RSVD   = 2'b11
    } in_cnf_e;

    typedef struct packed {
        logic oe;
        logic dout;
        logic pu;
        logic pd;
        logic ie;
    } pin_drv_t;
endpackage

// File: rtl/gpio_regs.sv
// Register file: configuration words and output latch.
// Applies direct, set/clear and clear-only writes to the latch.
// Assumes NPINS is 8 or 16, so the fields fill whole 32-bit words
// and the clear half of the set/clear word fits in bits 31:16.
module gpio_regs
    import gpio_cfg_pkg::*;
#(
    parameter int unsigned NPINS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wen,
    input  logic [REG_AW-1:0]          addr,
    input  logic [31:0]                wdata,
    output logic [NPINS*FIELD_W-1:0]   cfg_q,
    output logic [NPINS-1:0]           odr_q
);
    localparam int unsigned CFG_BITS  = NPINS * FIELD_W;
    localparam int unsigned CFG_WORDS = CFG_BITS / 32;

    // Purpose: hold the configuration fields, written one word at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= {NPINS{FIELD_RST}};
        end else if (wen) begin
            for (int w = 0; w < CFG_WORDS; w++) begin
                if (addr == REG_AW'(w))
                    cfg_q[w*32 +: 32] <= wdata;
            end
        end
    end

    // Purpose: update the output latch. Set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odr_q <= '0;
        end else if (wen) begin
            unique case (addr)
                A_ODR:   odr_q <= wdata[NPINS-1:0];
                A_BSR:   odr_q <= (odr_q & ~wdata[16 +: NPINS]) | wdata[NPINS-1:0];
                A_CLR:   odr_q <= odr_q & ~wdata[NPINS-1:0];
                default: odr_q <= odr_q;
            endcase
        end
    end

    // R3: every bit selected for setting is 1 after the write.
    assert_bsr_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && addr == A_BSR) |=>
            ((odr_q & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0])));

    // R3: clear-only bits (set bit 0) are 0 after the write.
    assert_bsr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && addr == A_BSR) |=>
            ((odr_q & $past(wdata[16 +: NPINS]) & ~$past(wdata[NPINS-1:0])) == '0));

    // R4: selected bits are cleared by the clear-only register.
    assert_clr_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && addr == A_CLR) |=> ((odr_q & $past(wdata[NPINS-1:0])) == '0));

    // R11: configuration is stable unless one of its words is written.
    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wen && addr < REG_AW'(CFG_WORDS)) |=> $stable(cfg_q));
endmodule

// File: rtl/gpio_pin_ctrl.sv
// Per-pin driver control: decodes one 4-bit field (mode in [1:0],
// config in [3:2]) with the output latch bit and peripheral value
// into pad controls. Combinational; clk and rst_n serve the checks.
module gpio_pin_ctrl
    import gpio_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] field,
    input  logic               odr_bit,
    input  logic               af_bit,
    output pin_drv_t           drv
);
    logic [1:0] mode;
    logic [1:0] cnf;
    logic       out_mode;
    logic       drv_val;

    assign mode     = field[1:0];
    assign cnf      = field[3:2];
    assign out_mode = (mode != 2'b00);
    // Purpose: pick the value source for output modes.
    assign drv_val  = cnf[1] ? af_bit : odr_bit;

    // Purpose: decode the pad controls from the mode and config bits.
    always_comb begin
        drv = '0;
        if (out_mode) begin
            drv.ie = 1'b1;
            if (cnf[0]) begin
                drv.oe   = ~drv_val;
                drv.dout = 1'b0;
            end else begin
                drv.oe   = 1'b1;
                drv.dout = drv_val;
            end
        end else begin
            unique case (in_cnf_e'(cnf))
                IN_ANALOG: drv.ie = 1'b0;
                IN_PULL: begin
                    drv.ie = 1'b1;
                    drv.pu = odr_bit;
                    drv.pd = ~odr_bit;
                end
                default:   drv.ie = 1'b1;
            endcase
        end
    end

    // R6: an open-drain pin never drives a high level.
    assert_od_no_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode && cnf[0] && drv.oe) |-> !drv.dout);

    // R9: pulls only in input mode, never both.
    assert_pull_input_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drv.pu || drv.pd) |-> (!out_mode && !(drv.pu && drv.pd)));

    // R7: a push-pull peripheral-driven pin follows the peripheral value.
    assert_af_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode && cnf == 2'b10) |-> (drv.oe && drv.dout == af_bit));

    // R8: input modes never drive the pad.
    assert_input_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_mode |-> !drv.oe);
endmodule

// File: rtl/gpio_in_sample.sv
// Input register: captures the pad levels on every clock edge and
// masks pins whose sampler is off (analog) to 0.
module gpio_in_sample #(
    parameter int unsigned NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] samp_en,
    output logic [NPINS-1:0] idr_q
);
    // Purpose: capture the enabled pad levels every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) idr_q <= '0;
        else        idr_q <= pin_in & samp_en;
    end

    // R10: a pin whose sampler was off at the edge reads 0.
    assert_analog_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((idr_q & ~$past(samp_en)) == '0));
endmodule

// File: rtl/gpio_port.sv
// Top of the pin port. It ties together the register file, one driver
// decoder per pin and the input register, and serves reads
// combinationally. Assumes NPINS is 8 or 16.
module gpio_port
    import gpio_cfg_pkg::*;
#(
    parameter int unsigned NPINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wen,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  af_in,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_dout,
    output logic [NPINS-1:0]  pin_pu,
    output logic [NPINS-1:0]  pin_pd,
    output logic [NPINS-1:0]  pin_ie
);
    localparam int unsigned CFG_BITS  = NPINS * FIELD_W;
    localparam int unsigned CFG_WORDS = CFG_BITS / 32;

    logic [CFG_BITS-1:0] cfg_q;
    logic [NPINS-1:0]    odr_q;
    logic [NPINS-1:0]    idr_q;

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (bus_wen),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cfg_q (cfg_q),
        .odr_q (odr_q)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pin_drv_t drv;
        gpio_pin_ctrl u_ctrl (
            .clk     (clk),
            .rst_n   (rst_n),
            .field   (cfg_q[p*FIELD_W +: FIELD_W]),
            .odr_bit (odr_q[p]),
            .af_bit  (af_in[p]),
            .drv     (drv)
        );
        assign pin_oe[p]   = drv.oe;
        assign pin_dout[p] = drv.dout;
        assign pin_pu[p]   = drv.pu;
        assign pin_pd[p]   = drv.pd;
        assign pin_ie[p]   = drv.ie;
    end

    gpio_in_sample #(.NPINS(NPINS)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .samp_en (pin_ie),
        .idr_q   (idr_q)
    );

    // Purpose: select the read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < CFG_WORDS; w++) begin
            if (bus_addr == REG_AW'(w))
                bus_rdata = cfg_q[w*32 +: 32];
        end
        if (bus_addr == A_IDR) bus_rdata = 32'(idr_q);
        if (bus_addr == A_ODR) bus_rdata = 32'(odr_q);
    end

    // R11: the write-only set/clear locations always read 0.
    assert_wo_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_BSR || bus_addr == A_CLR) |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    localparam int  CLK_PERIOD = 10;
    localparam int  N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_in = '0, af_in = '0;
    logic [N-1:0] pin_oe, pin_dout, pin_pu, pin_pd, pin_ie;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port #(.NPINS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .af_in(af_in), .pin_oe(pin_oe), .pin_dout(pin_dout),
        .pin_pu(pin_pu), .pin_pd(pin_pd), .pin_ie(pin_ie)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(posedge clk);
        #1 bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Spec model of one pin: {oe, dout, pu, pd, ie}.
    function automatic logic [4:0] model(input logic [3:0] f, input logic o, input logic a);
        logic [1:0] m, c;
        logic v;
        m = f[1:0]; c = f[3:2];
        if (m != 2'b00) begin
            v = c[1] ? a : o;
            if (c[0]) return {~v, 1'b0, 1'b0, 1'b0, 1'b1};
            return {1'b1, v, 1'b0, 1'b0, 1'b1};
        end
        if (c == 2'b00) return 5'b00000;
        if (c == 2'b10) return {1'b0, 1'b0, o, ~o, 1'b1};
        return 5'b00001;
    endfunction

    function automatic string tag_of(input logic [3:0] f);
        if (f[1:0] != 2'b00) return f[3] ? "R7" : (f[2] ? "R6" : "R5");
        return (f[3:2] == 2'b00) ? "R10" : "R8";
    endfunction

    // Compare all pad outputs against the model for per-pin fields.
    task automatic check_pins(input logic [63:0] cfg, input logic [N-1:0] o);
        logic [N-1:0] e_oe, e_do, e_pu, e_pd, e_ie;
        string t;
        for (int p = 0; p < N; p++) begin
            logic [4:0] r;
            r = model(cfg[p*4 +: 4], o[p], af_in[p]);
            {e_oe[p], e_do[p], e_pu[p], e_pd[p], e_ie[p]} = r;
        end
        t = tag_of(cfg[3:0]);
        @(negedge clk); #1;
        chk({t, " oe"},   32'(pin_oe),   32'(e_oe));
        chk({t, " dout"}, 32'(pin_dout), 32'(e_do));
        chk("R9 pull-up",   32'(pin_pu), 32'(e_pu));
        chk("R9 pull-down", 32'(pin_pd), 32'(e_pd));
        chk({t, " ie"},   32'(pin_ie),   32'(e_ie));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] d;
        logic [N-1:0] odr_m;
        logic [31:0] lcg;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, d); chk("R1 cfg word 0", d, 32'h4444_4444);
        rd(3'd1, d); chk("R1 cfg word 1", d, 32'h4444_4444);
        rd(3'd3, d); chk("R1 output latch", d, 32'h0);
        chk("R1 oe", 32'(pin_oe), 32'h0);
        chk("R1 pulls", 32'(pin_pu | pin_pd), 32'h0);
        chk("R1 ie", 32'(pin_ie), 32'h0000_FFFF);

        // R2 capture every edge, one-edge delay
        @(negedge clk); pin_in = 16'hBEEF;
        rd(3'd2, d); chk("R2 captured", d, 32'h0000_BEEF);
        @(negedge clk); pin_in = 16'h1234;
        #1 chk("R2 before edge holds old", bus_rdata, 32'h0000_BEEF);
        rd(3'd2, d); chk("R2 after edge", d, 32'h0000_1234);

        // R11 writes to input register ignored; map and unused addresses
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, d); chk("R11 input reg write ignored", d, 32'h0000_1234);
        wr(3'd3, 32'hFFFF_A5A5);
        rd(3'd3, d); chk("R11 latch upper bits read 0", d, 32'h0000_A5A5);
        rd(3'd6, d); chk("R11 addr 6 reads 0", d, 32'h0);
        rd(3'd7, d); chk("R11 addr 7 reads 0", d, 32'h0);
        wr(3'd0, 32'h7654_3210);
        wr(3'd1, 32'hFEDC_BA98);
        rd(3'd0, d); chk("R11 cfg word 0 readback", d, 32'h7654_3210);
        rd(3'd1, d); chk("R11 cfg word 1 readback", d, 32'hFEDC_BA98);

        // Mixed map: pin k has field k (R5-R10 all at once)
        af_in = 16'h6C39;
        check_pins(64'hFEDC_BA98_7654_3210, 16'hA5A5);

        // R10 analog pins 0-7 read 0 in the input register
        wr(3'd0, 32'h0000_0000);
        wr(3'd1, 32'h4444_4444);
        @(negedge clk); pin_in = 16'hFFFF;
        rd(3'd2, d); chk("R10 analog bits read 0", d, 32'h0000_FF00);

        // Uniform sweep of every field value with two data patterns
        for (int f = 0; f < 16; f++) begin
            for (int p = 0; p < 2; p++) begin
                logic [N-1:0] o;
                o = p[0] ? 16'h5AC3 : 16'hA53C;
                af_in = p[0] ? 16'h0FF0 : 16'hC3A5;
                wr(3'd0, {8{f[3:0]}});
                wr(3'd1, {8{f[3:0]}});
                wr(3'd3, 32'(o));
                check_pins({16{f[3:0]}}, o);
            end
        end

        // R3 / R4 set/clear sequence, tracked by an arithmetic model
        wr(3'd3, 32'h0000_00F0);
        odr_m = 16'h00F0;
        wr(3'd4, 32'h0F0F_0101);
        odr_m = 16'h01F1;   // set wins on bits 0 and 8
        rd(3'd3, d); chk("R3 set wins and selective", d, 32'(odr_m));
        rd(3'd4, d); chk("R3 reads 0", d, 32'h0);
        wr(3'd4, 32'h0000_0000);
        rd(3'd3, d); chk("R3 zero write no effect", d, 32'(odr_m));
        wr(3'd5, 32'hFFFF_0030);
        odr_m = 16'h01C1;
        rd(3'd3, d); chk("R4 clear-only, upper ignored", d, 32'(odr_m));
        rd(3'd5, d); chk("R4 reads 0", d, 32'h0);
        lcg = 32'h1357_9BDF;
        for (int i = 0; i < 24; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            if (i % 3 == 2) begin
                wr(3'd5, lcg);
                odr_m = odr_m & ~lcg[15:0];
                rd(3'd3, d); chk("R4 random clear", d, 32'(odr_m));
            end else begin
                wr(3'd4, lcg);
                odr_m = (odr_m & ~lcg[31:16]) | lcg[15:0];
                rd(3'd3, d); chk("R3 random set/clear", d, 32'(odr_m));
            end
        end
        // Latch visible on push-pull pins (R5)
        wr(3'd0, 32'h1111_1111);
        wr(3'd1, 32'h1111_1111);
        check_pins({16{4'h1}}, odr_m);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule